// File: doc/BRIEF.md
# Two-Road Sensor-Driven Traffic Light Controller

This block sequences the signal lamps at a crossing of two roads, called road A and road B. Each road has one vehicle sensor. The controller keeps green on a road for as long as that road's sensor reports traffic. When the sensor goes quiet, the road shows yellow for a single clock step, and then green passes to the other road. The block is a Moore machine. Both lamp codes depend only on the registered phase. The sensors affect only the choice of the next phase.

There are four phases, held in a two-bit register:

| Phase | Code | Road A | Road B |
|---|---|---|---|
| `PH_A_GO` | 00 | green | red |
| `PH_A_WARN` | 01 | yellow | red |
| `PH_B_GO` | 10 | red | green |
| `PH_B_WARN` | 11 | red | yellow |

The transitions are named as follows:

- **a_hold**: `PH_A_GO` to `PH_A_GO` while `sense_a` is 1.
- **a_release**: `PH_A_GO` to `PH_A_WARN` when `sense_a` is 0.
- **a_handover**: `PH_A_WARN` to `PH_B_GO`, unconditional.
- **b_hold**: `PH_B_GO` to `PH_B_GO` while `sense_b` is 1.
- **b_release**: `PH_B_GO` to `PH_B_WARN` when `sense_b` is 0.
- **b_handover**: `PH_B_WARN` to `PH_A_GO`, unconditional.

The next phase is formed combinationally during a cycle and is loaded into the register at the following rising clock edge. The current phase is also driven out on a two-bit debug port.

Top module: `xroad_light_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge puts the phase at 00. After that edge, `lamp_a` reads 00 (green) and `lamp_b` reads 10 (red).
- R2: In phase 00, the phase stays 00 at the next edge if `sense_a`=1 (a_hold) and becomes 01 if `sense_a`=0 (a_release).
- R3: Phase 01 always becomes 10 at the next edge, whatever the sensor values (a_handover).
- R4: In phase 10, the phase stays 10 at the next edge if `sense_b`=1 (b_hold) and becomes 11 if `sense_b`=0 (b_release).
- R5: Phase 11 always becomes 00 at the next edge, whatever the sensor values (b_handover).
- R6: The lamp codes are green=00, yellow=01 and red=10. The (`lamp_a`,`lamp_b`) pair is (00,10) in phase 00, (01,10) in phase 01, (10,00) in phase 10 and (10,01) in phase 11.
- R7: Neither lamp output ever shows the code 11.
- R8: At every clock edge outside reset, at least one of the two lamps is red (10). The two roads are never both green or yellow at the same time.
- R9: The lamps and `phase_dbg` depend only on the registered phase. A sensor change between edges leaves them unchanged. `phase_dbg` equals the phase code in the table.
- R10: A yellow lamp (01) lasts exactly one cycle. In the cycle after yellow on a road, that road shows red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sense_a | input | 1 | Road A traffic sensor, synchronous to clk |
| sense_b | input | 1 | Road B traffic sensor, synchronous to clk |
| lamp_a | output | 2 | Road A lamp code (00 green, 01 yellow, 10 red) |
| lamp_b | output | 2 | Road B lamp code (00 green, 01 yellow, 10 red) |
| phase_dbg | output | 2 | Current phase code, for debug |

## Verification
The properties assume that both sensor bits are synchronous to `clk` and settle well before each rising edge, so that every transition is decided on a stable value. The stimulus always changes the sensors one time unit after a rising edge, never close to the sampling edge. It drives both sensor values during the yellow phases, to show that those values are ignored there. A mid-cycle sensor toggle exercises the claim that the lamps follow state only.

// File: rtl/xroad_pkg.sv
package xroad_pkg;

    localparam int ROADS   = 2;
    localparam int PHASE_W = 2;
    localparam int LAMP_W  = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_t;

    typedef enum logic [LAMP_W-1:0] {
        LAMP_GO   = 2'b00,
        LAMP_WARN = 2'b01,
        LAMP_STOP = 2'b10
    } lamp_t;

    localparam int ROAD_A = 0;
    localparam int ROAD_B = 1;

endpackage

// File: rtl/xroad_phase_next.sv
module xroad_phase_next
    import xroad_pkg::*;
(
    input  phase_t           cur,
    input  logic [ROADS-1:0] sense,
    output phase_t           nxt
);

    // Sensors only steer the choice out of the two green phases.
    always_comb begin
        nxt = cur;
        unique case (cur)
            PH_A_GO:   nxt = sense[ROAD_A] ? PH_A_GO : PH_A_WARN;  // a_hold / a_release
            PH_A_WARN: nxt = PH_B_GO;                              // a_handover
            PH_B_GO:   nxt = sense[ROAD_B] ? PH_B_GO : PH_B_WARN;  // b_hold / b_release
            PH_B_WARN: nxt = PH_A_GO;                              // b_handover
            default:   nxt = PH_A_GO;
        endcase
    end

endmodule

// File: rtl/xroad_lamp_map.sv
module xroad_lamp_map
    import xroad_pkg::*;
#(
    parameter phase_t GO_PH   = PH_A_GO,
    parameter phase_t WARN_PH = PH_A_WARN
) (
    input  phase_t cur,
    output lamp_t  lamp
);

    // Moore decode: lamp follows the registered phase only.
    always_comb begin
        if (cur == GO_PH)
            lamp = LAMP_GO;
        else if (cur == WARN_PH)
            lamp = LAMP_WARN;
        else
            lamp = LAMP_STOP;
    end

endmodule

// File: rtl/xroad_light_ctrl.sv
module xroad_light_ctrl
    import xroad_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sense_a,
    input  logic               sense_b,
    output logic [LAMP_W-1:0]  lamp_a,
    output logic [LAMP_W-1:0]  lamp_b,
    output logic [PHASE_W-1:0] phase_dbg
);

    phase_t           phase_q;
    phase_t           phase_d;
    logic [ROADS-1:0] sense_vec;
    lamp_t            lamps [ROADS];

    assign sense_vec[ROAD_A] = sense_a;
    assign sense_vec[ROAD_B] = sense_b;

    xroad_phase_next u_next (
        .cur   (phase_q),
        .sense (sense_vec),
        .nxt   (phase_d)
    );

    // Phase register
    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_A_GO;
        else
            phase_q <= phase_d;
    end

    // One lamp decoder per road
    for (genvar r = 0; r < ROADS; r++) begin : g_road
        localparam phase_t GO_P   = (r == ROAD_A) ? PH_A_GO   : PH_B_GO;
        localparam phase_t WARN_P = (r == ROAD_A) ? PH_A_WARN : PH_B_WARN;
        xroad_lamp_map #(
            .GO_PH   (GO_P),
            .WARN_PH (WARN_P)
        ) u_map (
            .cur  (phase_q),
            .lamp (lamps[r])
        );
    end

    // Outputs
    always_comb begin
        lamp_a    = lamps[ROAD_A];
        lamp_b    = lamps[ROAD_B];
        phase_dbg = phase_q;
    end

endmodule

// File: rtl/xroad_light_chk.sv
module xroad_light_chk (
    input logic       clk,
    input logic       rst,
    input logic       sense_a,
    input logic       sense_b,
    input logic [1:0] lamp_a,
    input logic [1:0] lamp_b,
    input logic [1:0] phase_dbg
);

    // R2
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_dbg == 2'b00 && sense_a) |=> phase_dbg == 2'b00);
    // R2
    a_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_dbg == 2'b00 && !sense_a) |=> phase_dbg == 2'b01);
    // R3
    a_handover_chk: assert property (@(posedge clk) disable iff (rst)
        phase_dbg == 2'b01 |=> phase_dbg == 2'b10);
    // R4
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_dbg == 2'b10 && sense_b) |=> phase_dbg == 2'b10);
    // R4
    b_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_dbg == 2'b10 && !sense_b) |=> phase_dbg == 2'b11);
    // R5
    b_handover_chk: assert property (@(posedge clk) disable iff (rst)
        phase_dbg == 2'b11 |=> phase_dbg == 2'b00);
    // R6
    a_green_map_chk: assert property (@(posedge clk) disable iff (rst)
        phase_dbg == 2'b00 |-> (lamp_a == 2'b00 && lamp_b == 2'b10));
    // R6
    b_yellow_map_chk: assert property (@(posedge clk) disable iff (rst)
        phase_dbg == 2'b11 |-> (lamp_a == 2'b10 && lamp_b == 2'b01));
    // R7
    no_bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        lamp_a != 2'b11 && lamp_b != 2'b11);
    // R8
    one_red_chk: assert property (@(posedge clk) disable iff (rst)
        lamp_a == 2'b10 || lamp_b == 2'b10);
    // R10
    a_yellow_once_chk: assert property (@(posedge clk) disable iff (rst)
        lamp_a == 2'b01 |=> lamp_a == 2'b10);
    // R10
    b_yellow_once_chk: assert property (@(posedge clk) disable iff (rst)
        lamp_b == 2'b01 |=> lamp_b == 2'b10);

endmodule

bind xroad_light_ctrl xroad_light_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sense_a   (sense_a),
    .sense_b   (sense_b),
    .lamp_a    (lamp_a),
    .lamp_b    (lamp_b),
    .phase_dbg (phase_dbg)
);

// File: tb/xroad_light_ctrl_tb_top.sv
module xroad_light_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sense_a = 1'b0;
    logic       sense_b = 1'b0;
    logic [1:0] lamp_a;
    logic [1:0] lamp_b;
    logic [1:0] phase_dbg;

    int n_checks = 0;
    int n_fails  = 0;
    logic [1:0] exp_ph = 2'b00;
    logic [1:0] prev_a = 2'b00;
    logic [1:0] prev_b = 2'b10;
    bit done = 1'b0;

    xroad_light_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .sense_a   (sense_a),
        .sense_b   (sense_b),
        .lamp_a    (lamp_a),
        .lamp_b    (lamp_b),
        .phase_dbg (phase_dbg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model built from the requirement table
    function automatic logic [1:0] ref_next(input logic [1:0] ph, input logic a, input logic b);
        case (ph)
            2'b00:   return a ? 2'b00 : 2'b01;
            2'b01:   return 2'b10;
            2'b10:   return b ? 2'b10 : 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [3:0] ref_lamps(input logic [1:0] ph);
        case (ph)
            2'b00:   return 4'b00_10;
            2'b01:   return 4'b01_10;
            2'b10:   return 4'b10_00;
            default: return 4'b10_01;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock with given sensors, then compare everything with the model
    task automatic step(input logic a, input logic b, input string req);
        sense_a = a;
        sense_b = b;
        @(posedge clk);
        #1;
        exp_ph = ref_next(exp_ph, a, b);
        check(req, {6'd0, phase_dbg}, {6'd0, exp_ph});
        check("R6", {4'd0, lamp_a, lamp_b}, {4'd0, ref_lamps(exp_ph)});
        check("R7", {6'd0, (lamp_a == 2'b11) || (lamp_b == 2'b11)}, 8'd0);
        check("R8", {7'd0, (lamp_a == 2'b10) || (lamp_b == 2'b10)}, 8'd1);
        if (prev_a == 2'b01) check("R10", {6'd0, lamp_a}, 8'b10);
        if (prev_b == 2'b01) check("R10", {6'd0, lamp_b}, 8'b10);
        prev_a = lamp_a;
        prev_b = lamp_b;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
        exp_ph = 2'b00;
        prev_a = 2'b00;
        prev_b = 2'b10;
        check("R1", {2'd0, phase_dbg, lamp_a, lamp_b}, 8'b00_00_00_10);
    endtask

    task automatic t_hold_a;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R2 a_hold");
        step(1'b0, 1'b1, "R2 a_release");
    endtask

    task automatic t_yellow_ignores;
        // in 01 with both sensors set: still advances
        step(1'b1, 1'b1, "R3 a_handover");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R4 b_hold");
        step(1'b1, 1'b0, "R4 b_release");
        step(1'b1, 1'b1, "R5 b_handover");
    endtask

    task automatic t_fast_cycle;
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R2 R3 R4 R5 fast cycle");
    endtask

    task automatic t_mid_cycle;
        logic [5:0] snap;
        // reach phase 00 then wiggle sensors between edges
        while (exp_ph != 2'b00) step(1'b0, 1'b0, "R5 approach");
        snap = {phase_dbg, lamp_a, lamp_b};
        for (int i = 0; i < 3; i++) begin
            sense_a = ~sense_a;
            sense_b = ~sense_b;
            #1;
            check("R9 mid-cycle", {2'd0, phase_dbg, lamp_a, lamp_b}, {2'd0, snap});
        end
        step(1'b1, 1'b1, "R2 a_hold after toggles");
    endtask

    task automatic t_reset_midway;
        step(1'b0, 1'b0, "R2 a_release");
        step(1'b0, 1'b0, "R3 a_handover");
        t_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hold_a();
        t_yellow_ignores();
        t_fast_cycle();
        t_mid_cycle();
        t_reset_midway();
        t_hold_a();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule